// File: doc/BRIEF.md
# Locality Access Arbiter

This block decides which of five requesters, called localities, owns a shared command interface. Each locality sees its own byte-wide access register. The register sits at offset zero of a register window, and address bits [14:12] select the window. A locality asks for the interface by writing a request bit into its own access register. The owner gives the interface up by writing the active bit.

Requests are recorded in one clock and granted in the next, and only while nobody owns the interface. When several requests wait together, the highest-numbered locality wins. The owner keeps the interface until it releases it; no other locality can take it away.

Every read of an access register shows three things: a valid flag, whether the reading locality is the owner, and whether some other locality is waiting. Each change of owner, whether a grant or a release, produces a one-cycle pulse for the interrupt logic.

Top module: `loc_arbiter`

## Requirements
- R1: After reset no locality owns the interface, and the access register of every locality reads 0x80.
- R2: A bus access reaches an access register only when address bits [11:0] are zero, bit 15 is zero and bits [14:12] hold a locality number from 0 to 4. Any other address reads 0x00, and a write to it changes nothing.
- R3: Bit 7 (valid) of every locality's access register reads 1 at all times.
- R4: Bit 5 (active) reads 1 only in the access register of the current owner.
- R5: A write with bit 1 set to a locality's access register records a request at the next clock edge. While nobody owns the interface, a recorded request is granted at the following clock edge, and the request is consumed by the grant.
- R6: When more than one request is recorded while the interface is free, the highest-numbered locality is granted.
- R7: Bit 2 (pending) reads 1 in every locality's access register while any locality other than the owner has a recorded request. Bit 1 reads 1 in a locality's own register while that locality's request is recorded.
- R8: A write with bit 5 set to the owner's access register frees the interface at the next clock edge. A waiting request is then granted one clock later.
- R9: A write of bit 5 by a locality that is not the owner has no effect. A write of bit 1 by the current owner is not recorded.
- R10: `locChange` is high for exactly the one cycle that follows each clock edge at which a grant or a release takes effect.
- R11: Once granted, the owner index stays unchanged until that owner releases the interface.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 16 | Register address; bits [14:12] select the locality window |
| busWr | input | 1 | Write strobe for one cycle |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr`, combinational |
| ownerValid | output | 1 | Some locality owns the interface |
| ownerIdx | output | 3 | Number of the owning locality, meaningful when `ownerValid` is high |
| locChange | output | 1 | One-cycle pulse for each grant or release |

## Verification
The bench keeps a behavioural model and compares ownership, the change pulse and the register read on every clock. Directed sequences then target the corner cases.

- Two requests queued behind an owner must go to the higher number. A wrong priority order would grant locality 1 instead of 3, and 0 instead of 4.
- A release written by a non-owner must not free the interface. A design that failed here would free it and hand it on early.
- An owner that writes release and request together must lose its request. Otherwise it would be granted again at once.
- A write to a nonzero offset or to window 5 must be ignored. A loose decoder would alias such writes onto a real access register.
- The grant must take exactly one clock after the request is recorded. The pulse count over the directed run catches a dropped or doubled change event.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;

  // Width of the locality field in the address; fixed by the address map.
  localparam int LOC_IDX_W = 3;
  localparam int LOC_SLOTS = 1 << LOC_IDX_W;

  // Access register bit positions, decoded by software.
  localparam int ACC_VALID_BIT  = 7;
  localparam int ACC_ACTIVE_BIT = 5;
  localparam int ACC_PEND_BIT   = 2;
  localparam int ACC_REQ_BIT    = 1;

  typedef logic [LOC_IDX_W-1:0] locIdx_t;

  // Strobes from the control to the register datapath.
  typedef struct packed {
    logic    grant;
    locIdx_t grantIdx;
  } arbStrobe_t;

endpackage

// File: rtl/loc_arb_regs.sv
module loc_arb_regs
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC   = 5,
  parameter int ADDR_W    = 16,
  parameter int WIN_SHIFT = 12,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  arbStrobe_t        ctlStrobe,
  input  logic              ownerValid,
  input  locIdx_t           ownerIdx,
  output logic [NUM_LOC-1:0] reqVec,
  output logic              relStrobe
);

  localparam int IDX_TOP = WIN_SHIFT + LOC_IDX_W;

  locIdx_t              winIdx;
  logic [WIN_SHIFT-1:0] winOfs;
  logic                 upperClear;
  logic                 accHit;
  logic                 isOwnerWin;
  logic                 pendAny;
  logic [LOC_SLOTS-1:0] reqWide;
  logic [DATA_W-1:0]    rdVal;

  assign winIdx = busAddr[WIN_SHIFT +: LOC_IDX_W];
  assign winOfs = busAddr[WIN_SHIFT-1:0];

  // Address bits above the locality field must be zero.
  generate
    if (ADDR_W > IDX_TOP) begin : g_upper
      assign upperClear = (busAddr[ADDR_W-1:IDX_TOP] == '0);
    end else begin : g_noUpper
      assign upperClear = 1'b1;
    end
  endgenerate

  assign accHit     = upperClear && (winOfs == '0) && (int'(winIdx) < NUM_LOC);
  assign isOwnerWin = ownerValid && (ownerIdx == winIdx);
  assign relStrobe  = busWr && accHit && busWrData[ACC_ACTIVE_BIT] && isOwnerWin;

  // One request flag per locality.
  generate
    for (genvar g = 0; g < NUM_LOC; g++) begin : g_req
      logic setReq;
      logic clrReq;
      logic ownedHere;
      assign ownedHere = ownerValid && (ownerIdx == locIdx_t'(g));
      assign setReq = busWr && accHit && (winIdx == locIdx_t'(g))
                      && busWrData[ACC_REQ_BIT] && !ownedHere;
      assign clrReq = ctlStrobe.grant && (ctlStrobe.grantIdx == locIdx_t'(g));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          reqVec[g] <= 1'b0;
        end else if (clrReq) begin
          reqVec[g] <= 1'b0;
        end else if (setReq) begin
          reqVec[g] <= 1'b1;
        end
      end
    end
  endgenerate

  assign reqWide = LOC_SLOTS'(reqVec);

  always_comb begin
    pendAny = 1'b0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (reqVec[i] && !(ownerValid && ownerIdx == locIdx_t'(i))) begin
        pendAny = 1'b1;
      end
    end
  end

  always_comb begin
    rdVal = '0;
    if (accHit) begin
      rdVal[ACC_VALID_BIT]  = 1'b1;
      rdVal[ACC_ACTIVE_BIT] = isOwnerWin;
      rdVal[ACC_PEND_BIT]   = pendAny;
      rdVal[ACC_REQ_BIT]    = reqWide[winIdx];
    end
  end

  assign busRdData = rdVal;

  AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rstN)
    ctlStrobe.grant |-> reqWide[ctlStrobe.grantIdx]); // R5
  AST_GRANT_HIGHEST: assert property (@(posedge clk) disable iff (!rstN)
    ctlStrobe.grant |-> ((reqWide >> ctlStrobe.grantIdx) == LOC_SLOTS'(1))); // R6
  AST_GRANT_CONSUMES: assert property (@(posedge clk) disable iff (!rstN)
    ctlStrobe.grant |=> !reqWide[$past(ctlStrobe.grantIdx)]); // R5
  AST_OWNER_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    ownerValid |-> !reqWide[ownerIdx]); // R9

endmodule

// File: rtl/loc_arb_ctrl.sv
module loc_arb_ctrl
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_LOC-1:0] reqVec,
  input  logic               relStrobe,
  output arbStrobe_t         ctlStrobe,
  output logic               ownerValid,
  output locIdx_t            ownerIdx,
  output logic               locChange
);

  locIdx_t pickIdx;
  logic    anyReq;
  logic    doGrant;

  // Later (higher) indices overwrite earlier ones: highest wins.
  always_comb begin
    pickIdx = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (reqVec[i]) begin
        pickIdx = locIdx_t'(i);
      end
    end
  end

  assign anyReq  = |reqVec;
  assign doGrant = !ownerValid && anyReq;

  assign ctlStrobe.grant    = doGrant;
  assign ctlStrobe.grantIdx = pickIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerValid <= 1'b0;
      ownerIdx   <= '0;
      locChange  <= 1'b0;
    end else begin
      locChange <= doGrant || relStrobe;
      if (doGrant) begin
        ownerValid <= 1'b1;
        ownerIdx   <= pickIdx;
      end else if (relStrobe) begin
        ownerValid <= 1'b0;
      end
    end
  end

  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rstN)
    (ownerValid && !relStrobe) |=> (ownerValid && $stable(ownerIdx))); // R11
  AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rstN)
    relStrobe |=> !ownerValid); // R8
  AST_FREE_GRANTS: assert property (@(posedge clk) disable iff (!rstN)
    (!ownerValid && anyReq) |=> ownerValid); // R5
  AST_OWNER_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ownerValid |-> (int'(ownerIdx) < NUM_LOC)); // R4

endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC   = 5,
  parameter int ADDR_W    = 16,
  parameter int WIN_SHIFT = 12,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWr,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  output logic                 ownerValid,
  output logic [LOC_IDX_W-1:0] ownerIdx,
  output logic                 locChange
);

  arbStrobe_t         ctlStrobe;
  logic [NUM_LOC-1:0] reqVec;
  logic               relStrobe;

  loc_arb_regs #(
    .NUM_LOC  (NUM_LOC),
    .ADDR_W   (ADDR_W),
    .WIN_SHIFT(WIN_SHIFT),
    .DATA_W   (DATA_W)
  ) i_regs (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .ctlStrobe (ctlStrobe),
    .ownerValid(ownerValid),
    .ownerIdx  (ownerIdx),
    .reqVec    (reqVec),
    .relStrobe (relStrobe)
  );

  loc_arb_ctrl #(
    .NUM_LOC(NUM_LOC)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqVec    (reqVec),
    .relStrobe (relStrobe),
    .ctlStrobe (ctlStrobe),
    .ownerValid(ownerValid),
    .ownerIdx  (ownerIdx),
    .locChange (locChange)
  );

  // Every change of owner passes through the free state, so the
  // valid flag toggles exactly at each grant and each release.
  AST_CHANGE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    locChange == (ownerValid != $past(ownerValid))); // R10

endmodule

// File: tb/test_loc_arbiter.sv
module test_loc_arbiter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWr = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        ownerValid;
  logic [2:0]  ownerIdx;
  logic        locChange;

  loc_arbiter i_loc_arbiter (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .ownerValid(ownerValid),
    .ownerIdx  (ownerIdx),
    .locChange (locChange)
  );

  always #4 clk = ~clk;   // 125 MHz

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  bit done = 1'b0;

  // Behavioural reference model.
  int mOwner = -1;
  bit mReq[5];
  bit mChange = 1'b0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int mRead(logic [15:0] a);
    int win;
    int r;
    bit pend;
    win = int'(a[14:12]);
    if (a[15] || a[11:0] != 0 || win >= 5) return 0;
    r = 'h80;
    if (mOwner == win) r = r | 'h20;
    pend = 1'b0;
    for (int i = 0; i < 5; i++) if (mReq[i] && i != mOwner) pend = 1'b1;
    if (pend) r = r | 'h04;
    if (mReq[win]) r = r | 'h02;
    return r;
  endfunction

  always @(posedge clk) begin
    int win;
    bit hit;
    bit rel;
    int pick;
    if (!rstN) begin
      mOwner = -1;
      for (int i = 0; i < 5; i++) mReq[i] = 1'b0;
      mChange = 1'b0;
    end else begin
      win = int'(busAddr[14:12]);
      hit = !busAddr[15] && busAddr[11:0] == 0 && win < 5;
      pick = -1;
      for (int i = 0; i < 5; i++) if (mReq[i]) pick = i;
      rel = busWr && hit && busWrData[5] && mOwner == win;
      if (busWr && hit && busWrData[1] && mOwner != win) mReq[win] = 1'b1;
      if (mOwner < 0 && pick >= 0) begin
        mOwner = pick;
        mReq[pick] = 1'b0;
        mChange = 1'b1;
      end else if (rel) begin
        mOwner = -1;
        mChange = 1'b1;
      end else begin
        mChange = 1'b0;
      end
    end
  end

  // Compare with the model on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R5 R6 R8 R11 owner valid", int'(ownerValid), int'(mOwner >= 0));
      if (mOwner >= 0) chk("R6 R11 owner index", int'(ownerIdx), mOwner);
      chk("R10 change pulse", int'(locChange), int'(mChange));
      chk("R3 R4 R7 read data", int'(busRdData), mRead(busAddr));
      if (locChange) pulses++;
    end
  end

  task automatic wrRaw(logic [15:0] a, logic [7:0] d);
    @(posedge clk);
    #1;
    busAddr = a;
    busWr = 1'b1;
    busWrData = d;
    @(posedge clk);
    #1;
    busWr = 1'b0;
  endtask

  task automatic wrAcc(int loc, logic [7:0] d);
    wrRaw(16'(loc << 12), d);
  endtask

  task automatic rdChk(logic [15:0] a, int exp, string tag);
    @(posedge clk);
    #1;
    busAddr = a;
    @(negedge clk);
    chk(tag, int'(busRdData), exp);
  endtask

  task automatic ownerChk(bit v, int idx, string tag);
    @(negedge clk);
    chk(tag, int'(ownerValid), int'(v));
    if (v) chk(tag, int'(ownerIdx), idx);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    #1 rstN = 1'b1;

    // R1 R3: reset state
    for (int l = 0; l < 5; l++) rdChk(16'(l << 12), 'h80, "R1 R3 reset read");
    ownerChk(1'b0, 0, "R1 no owner after reset");

    // R2: decode misses
    rdChk(16'h5000, 'h00, "R2 window 5 reads zero");
    rdChk(16'h1018, 'h00, "R2 nonzero offset reads zero");
    rdChk(16'h8000, 'h00, "R2 bit 15 reads zero");
    wrRaw(16'h1018, 8'h02);
    idle(3);
    ownerChk(1'b0, 0, "R2 write to other offset ignored");
    rdChk(16'h1000, 'h80, "R2 no request recorded");

    // R5: request, then grant one clock later
    wrAcc(2, 8'h02);
    ownerChk(1'b0, 0, "R5 not granted yet");
    ownerChk(1'b1, 2, "R5 granted");

    // R7: queue two waiters behind owner 2
    wrAcc(1, 8'h02);
    wrAcc(3, 8'h02);
    rdChk(16'h0000, 'h84, "R7 pending in window 0");
    rdChk(16'h2000, 'hA4, "R4 R7 owner window");
    rdChk(16'h3000, 'h86, "R7 own request bit");

    // R11: owner held
    idle(10);
    ownerChk(1'b1, 2, "R11 no preemption");

    // R9: non-owner release, owner request
    wrAcc(3, 8'h20);
    wrAcc(2, 8'h02);
    ownerChk(1'b1, 2, "R9 non-owner release ignored");
    rdChk(16'h2000, 'hA4, "R9 owner request not recorded");

    // R2: write to owner window at another offset
    wrRaw(16'h2004, 8'h20);
    idle(2);
    ownerChk(1'b1, 2, "R2 offset write does not release");

    // R8 R6: release, then highest waiter
    wrAcc(2, 8'h20);
    ownerChk(1'b0, 0, "R8 freed");
    ownerChk(1'b1, 3, "R6 R8 highest waiter granted");
    wrAcc(3, 8'h20);
    ownerChk(1'b0, 0, "R8 freed again");
    ownerChk(1'b1, 1, "R8 remaining waiter granted");
    rdChk(16'h1000, 'hA0, "R4 R7 no pending");

    // R6: localities 0 and 4 both waiting
    wrAcc(0, 8'h02);
    wrAcc(4, 8'h02);
    wrAcc(1, 8'h20);
    ownerChk(1'b0, 0, "R8 freed by locality 1");
    ownerChk(1'b1, 4, "R6 locality 4 beats 0");
    wrAcc(4, 8'h22);
    ownerChk(1'b0, 0, "R8 R9 release with request");
    ownerChk(1'b1, 0, "R6 R9 locality 0 granted");
    rdChk(16'h4000, 'h80, "R9 owner request dropped");
    wrAcc(0, 8'h20);
    idle(2);
    chk("R10 pulse count", pulses, 10);

    // Mixed traffic, compared against the model every clock.
    for (int n = 0; n < 400; n++) begin
      int loc;
      int sel;
      logic [7:0] d;
      loc = int'($urandom_range(0, 5));
      sel = int'($urandom_range(0, 5));
      case (sel)
        0: d = 8'h02;
        1: d = 8'h20;
        2: d = 8'h22;
        3: d = 8'hFF;
        4: d = 8'h00;
        default: d = 8'h02;
      endcase
      if ($urandom_range(0, 3) == 0) begin
        idle(int'($urandom_range(1, 3)));
      end else if ($urandom_range(0, 7) == 0) begin
        wrRaw(16'((loc << 12) | 4), d);
      end else begin
        wrAcc(loc, d);
      end
    end
    idle(4);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule